// File: doc/BRIEF.md
# Serial Cyclic Block Check Encoder and Verifier

This unit guards fixed-length serial message blocks with a 22-bit cyclic check. A block is 1024 bit times long. In encode mode the first 1002 bits are payload. They pass straight through to the serial output while a 22-stage feedback shift register divides them by the generator polynomial x^22 + x^13 + x^2 + 1. For the last 22 bit times the register stops feeding back and shifts its remainder out as check digits.

In verify mode all 1024 received bits, check digits included, pass through the same divider and are echoed on the output. When the block ends, the unit reports a pass only if the remainder is all zeros. A start-of-block strobe clears the divider and the bit count, and it latches the mode for that block. Bits are accepted only on cycles where the valid strobe is high, so the bit rate may be slower than the clock and may have gaps.

Top module: `cyclic_block_codec`

## Requirements
- R1: After reset, out_valid, res_valid and res_pass are all low, and no bit is accepted until a start-of-block strobe arrives.
- R2: In encode mode (chk_mode=0 at start), the first 1002 accepted bits appear unchanged on out_bit. Each one appears with out_valid high in the cycle after the bit is accepted.
- R3: In encode mode, accepted bit times 1003 to 1024 output the remainder of payload·x^22 divided by x^22+x^13+x^2+1. The x^21 coefficient comes first. The input bit values in those bit times have no effect.
- R4: In verify mode (chk_mode=1 at start), every accepted bit is echoed on out_bit one cycle later. The verdict is a pass exactly when the 1024-bit block, first bit taken as the x^1023 coefficient, is divisible by the generator.
- R5: A valid codeword that has any odd number of flipped bits, or a single burst of 22 bits or fewer, is reported as a fail.
- R6: In verify mode, res_valid is high for exactly one cycle, the cycle after the 1024th bit is accepted. res_pass then holds the verdict until the next start strobe. Encode mode never raises res_valid.
- R7: A start strobe clears the divider and the count, even in the middle of a block. If bit_vld is high in the same cycle, that bit is bit 1 of the new block. The start strobe also clears res_pass.
- R8: Bits offered with bit_vld low, or after the 1024th bit and before the next start strobe, produce no output and do not change res_pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sob | input | 1 | Start of block: clears the divider and latches the mode |
| chk_mode | input | 1 | 0 = encode, 1 = verify; sampled with sob |
| bit_vld | input | 1 | Qualifies bit_in for one bit time |
| bit_in | input | 1 | Serial input bit |
| out_bit | output | 1 | Serial output bit |
| out_valid | output | 1 | out_bit carries a bit this cycle |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_pass | output | 1 | Verdict: remainder was zero |

## Verification
The bench targets the switch from payload to check digits at bit 1003. A design that keeps feedback running there, or shifts the remainder LSB first, emits wrong check digits, and the verifier then rejects its own codewords. The bench corrupts codewords with one error, with three errors, and with a full 22-bit burst whose end bits are set. A wrong tap would let some of these pass. The bench also restarts a block part way through and sends bits after a block has finished. A design that fails to clear on the start strobe gives a wrong verdict for the next block, and a design that keeps counting emits stray output bits. Finally, the bench checks that the verdict stays on res_pass after its one-cycle strobe, that the strobe itself lasts only one cycle, and that the start strobe clears the verdict.

// File: rtl/cyclic_block_codec.sv
module cyclic_block_codec #(
  parameter int          BLK_LEN = 1024,
  parameter int          CHK_W   = 22,
  parameter logic [21:0] TAPS    = 22'h002005
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sob,
  input  logic chk_mode,
  input  logic bit_vld,
  input  logic bit_in,
  output logic out_bit,
  output logic out_valid,
  output logic res_valid,
  output logic res_pass
);
  localparam int PAY_LEN = BLK_LEN - CHK_W;
  localparam int CW      = $clog2(BLK_LEN + 1);

  logic [CHK_W-1:0] rem_q, base_rem, rem_nxt;
  logic [CW-1:0]    cnt_q, base_cnt;
  logic             active_q, mode_q, cur_chk, take, tail, fb, last, nxt_out;

  assign base_rem = sob ? '0 : rem_q;
  assign base_cnt = sob ? '0 : cnt_q;
  assign cur_chk  = sob ? chk_mode : mode_q;
  assign take     = bit_vld && (sob || active_q);
  assign tail     = !cur_chk && (base_cnt >= CW'(PAY_LEN));
  assign fb       = tail ? 1'b0 : (bit_in ^ base_rem[CHK_W-1]);
  assign rem_nxt  = {base_rem[CHK_W-2:0], 1'b0} ^ (fb ? TAPS[CHK_W-1:0] : '0);
  assign nxt_out  = tail ? base_rem[CHK_W-1] : bit_in;
  assign last     = take && (base_cnt == CW'(BLK_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q     <= '0;
      cnt_q     <= '0;
      active_q  <= 1'b0;
      mode_q    <= 1'b0;
      out_bit   <= 1'b0;
      out_valid <= 1'b0;
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
    end else begin
      out_valid <= take;
      res_valid <= last && cur_chk;
      if (sob) mode_q <= chk_mode;
      if (take) begin
        rem_q   <= rem_nxt;
        cnt_q   <= base_cnt + 1'b1;
        out_bit <= nxt_out;
      end else if (sob) begin
        rem_q <= '0;
        cnt_q <= '0;
      end
      if (last)     active_q <= 1'b0;
      else if (sob) active_q <= 1'b1;
      if (last && cur_chk) res_pass <= (rem_nxt == '0);
      else if (sob)        res_pass <= 1'b0;
    end
  end

  assert_res_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_pass_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sob && !last) |=> $stable(res_pass));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !out_valid);
  assert_sob_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sob && !last) |=> !res_pass);
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < CW'(BLK_LEN)));
  assert_encode_no_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !cur_chk) |=> !res_valid);
endmodule

// File: tb/test_cyclic_block_codec.sv
`timescale 1ns/1ps
module test_cyclic_block_codec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sob = 1'b0, chk_mode = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic out_bit, out_valid, res_valid, res_pass;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];
  bit res_q[$];
  string rtag_q[$];
  bit prev_rv = 1'b0;

  always #2 clk = ~clk;

  cyclic_block_codec i_cyclic_block_codec (
    .clk(clk), .rst_n(rst_n), .sob(sob), .chk_mode(chk_mode),
    .bit_vld(bit_vld), .bit_in(bit_in), .out_bit(out_bit),
    .out_valid(out_valid), .res_valid(res_valid), .res_pass(res_pass));

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // long division over send order: index 0 is the x^1023 coefficient
  function automatic logic [1023:0] divide(input logic [1023:0] d);
    for (int i = 0; i < 1002; i++)
      if (d[i]) begin
        d[i] = ~d[i]; d[i+9] = ~d[i+9]; d[i+20] = ~d[i+20]; d[i+22] = ~d[i+22];
      end
    return d;
  endfunction

  function automatic logic [1023:0] encode(input logic [1023:0] p);
    logic [1023:0] z, r;
    z = p;
    for (int i = 1002; i < 1024; i++) z[i] = 1'b0;
    r = divide(z);
    for (int i = 1002; i < 1024; i++) z[i] = r[i];
    return z;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check("R8 stray output", 1'b1, 1'b0);
        else check(tag_q.pop_front(), out_bit, exp_q.pop_front());
      end
      if (res_valid) begin
        if (res_q.size() == 0) check("R6 stray verdict", 1'b1, 1'b0);
        else check(rtag_q.pop_front(), res_pass, res_q.pop_front());
      end
      if (prev_rv && res_valid) check("R6 single-cycle strobe", 1'b1, 1'b0);
      prev_rv <= res_valid;
    end
  end

  task automatic send(input logic m, input logic [1023:0] bits, input int nbits,
                      input int gap, input logic exp_pass, input string rtag);
    logic [1023:0] enc;
    enc = encode(bits);
    for (int i = 0; i < nbits; i++) begin
      if (m) begin
        exp_q.push_back(bits[i]); tag_q.push_back("R4 verify echo");
      end else if (i < 1002) begin
        exp_q.push_back(bits[i]); tag_q.push_back("R2 payload pass-through");
      end else begin
        exp_q.push_back(enc[i]); tag_q.push_back("R3 check digit");
      end
    end
    if (m && nbits == 1024) begin
      res_q.push_back(exp_pass); rtag_q.push_back(rtag);
    end
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sob = (i == 0); chk_mode = m; bit_vld = 1'b1;
      bit_in = (!m && i >= 1002) ? 1'($urandom) : bits[i];
      if (gap > 0 && (i % 7) == 3)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          sob = 1'b0; bit_vld = 1'b0; bit_in = 1'($urandom);
        end
    end
    @(negedge clk);
    sob = 1'b0; bit_vld = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check("R8 queue drained", exp_q.size() == 0 && res_q.size() == 0, 1'b1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [1023:0] pay, cw, bad;
    repeat (3) @(negedge clk);
    check("R1 out_valid reset", out_valid, 1'b0);
    check("R1 res_valid reset", res_valid, 1'b0);
    check("R1 res_pass reset", res_pass, 1'b0);
    rst_n = 1'b1;
    // R1/R8: bits before any start strobe are ignored
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bit_vld = 1'b1; bit_in = 1'($urandom);
    end
    @(negedge clk); bit_vld = 1'b0;
    drain();

    // R2/R3: encode random payload
    for (int i = 0; i < 1024; i++) pay[i] = 1'($urandom);
    cw = encode(pay);
    send(1'b0, pay, 1024, 0, 1'b0, "");
    drain();
    // R4: verify clean codeword, with gaps in bit_vld
    send(1'b1, cw, 1024, 2, 1'b1, "R4 clean codeword passes");
    drain();
    // R6: verdict held after strobe
    repeat (5) @(negedge clk);
    check("R6 pass held", res_pass, 1'b1);
    // R8: bits after block end ignored and verdict unchanged
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bit_vld = 1'b1; bit_in = 1'($urandom);
    end
    @(negedge clk); bit_vld = 1'b0;
    drain();
    check("R8 verdict unchanged", res_pass, 1'b1);
    // R7: start strobe clears verdict
    @(negedge clk); sob = 1'b1; chk_mode = 1'b1;
    @(negedge clk); sob = 1'b0;
    check("R7 sob clears res_pass", res_pass, 1'b0);

    // R5: single, triple, burst errors
    bad = cw; bad[517] = ~bad[517];
    send(1'b1, bad, 1024, 0, 1'b0, "R5 single error detected");
    drain();
    bad = cw; bad[3] = ~bad[3]; bad[400] = ~bad[400]; bad[1020] = ~bad[1020];
    send(1'b1, bad, 1024, 0, 1'b0, "R5 triple error detected");
    drain();
    bad = cw;
    for (int i = 600; i < 622; i++) bad[i] = bad[i] ^ ((i == 600 || i == 621) ? 1'b1 : 1'($urandom));
    send(1'b1, bad, 1024, 0, 1'b0, "R5 22-bit burst detected");
    drain();
    bad = cw;
    for (int i = 1002; i < 1024; i++) bad[i] = bad[i] ^ ((i == 1002 || i == 1023) ? 1'b1 : 1'($urandom));
    send(1'b1, bad, 1024, 0, 1'b0, "R5 burst in check digits detected");
    drain();

    // R3: all-zero payload gives all-zero check digits; inputs in tail ignored
    pay = '0;
    send(1'b0, pay, 1024, 0, 1'b0, "");
    drain();
    check("R6 encode gives no verdict", res_pass, 1'b0);

    // R7: abort mid-block, then a fresh verify of a new codeword
    for (int i = 0; i < 1024; i++) pay[i] = 1'($urandom);
    cw = encode(pay);
    send(1'b1, ~cw, 300, 0, 1'b0, "");
    send(1'b0, pay, 1024, 1, 1'b0, "");
    drain();
    send(1'b1, cw, 500, 0, 1'b0, "");
    send(1'b1, cw, 1024, 0, 1'b1, "R7 restart then clean pass");
    drain();
    summary();
  end
endmodule